// File: doc/BRIEF.md
# Stuck-at Fault Sweep Bit-Serial Adder

This block is a bit-serial adder for two short operands, made of one full adder and one carry register, wrapped so that any of its internal nets can be forced to a constant. A fault code chooses, for each of seven nets, whether the net behaves normally, is held at 0 or is held at 1. Setting one or two net controls gives single or double stuck-at conditions.

A built-in sweeper produces a fault dictionary for one fault code. A start pulse captures the code. The sweeper then walks through every operand pair in ascending order and shifts each pair into the adder one bit per clock, least-significant bit first. After the last bit it offers a record holding the operand pair, the sum word that came out of the faulted adder, the fault code, and a flag showing whether that sum differs from a fault-free copy of the adder running alongside. Records leave on a valid/ready handshake. After the last record a done flag is raised and held.

Top module: `fault_sweep_adder`

## Requirements
- R1: With fault code zero, each record's sum equals (x1 + x2) mod 2^WORD_W. The operand byte carries x1 in bits [7:4] and x2 in bits [3:0]. Bits enter least-significant first: sum bit = x1 ^ x2 ^ carry, and next carry = (x1 & x2) | ((x1 ^ x2) & carry).
- R2: The carry register is cleared before the first bit of every operand pair, so no record depends on the pair before it.
- R3: The fault code has 14 bits, two per net. Net k occupies bits [2k+1:2k], in this order for k = 0..6: x1 input, x2 input, first XOR output, generate AND (x1 & x2), propagate AND (XOR output & carry), OR output feeding the carry register, carry register output. Control values 00 and 01 leave the net alone, 10 holds it at 0 and 11 holds it at 1. A forced carry register output is seen by both the sum XOR and the propagate AND.
- R4: Two nets forced in the same code act together on every record.
- R5: A sweep gives exactly 256 records, with operand bytes 0 to 255 in ascending order.
- R6: With ready held high, a record becomes valid 5 clocks after the start edge and 5 clocks after each accepted record.
- R7: While valid is high and ready is low, the record stays valid and all of its fields hold their values.
- R8: The mismatch flag is 1 exactly when the record's sum differs from the fault-free sum for the same operands.
- R9: Done rises on the clock that accepts the last record and stays high, with valid low, until the next start. That start clears it.
- R10: The fault code is sampled on the start edge. Each record carries the sampled code, and changes on the fault code input during a sweep have no effect.
- R11: While reset is asserted, and after it, valid and done are low.
- R12: A start pulse during a sweep is ignored. The sweep continues in order to its 256th record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a sweep when the block is idle or done |
| fault_cfg | input | 14 | Per-net stuck-at controls, two bits per net |
| rec_ready | input | 1 | Consumer accepts the current record |
| rec_valid | output | 1 | A record is presented |
| rec_operands | output | 2*WORD_W | Operand pair: x1 high word, x2 low word |
| rec_sum | output | WORD_W | Sum word observed under the fault code |
| rec_fault | output | 14 | Fault code in force for this record |
| rec_mismatch | output | 1 | Sum differs from the fault-free sum |
| done | output | 1 | Sweep finished |

## Verification
The bench targets the nets whose faults only show in some words. A carry register that is not cleared per pair would corrupt the low bit of pairs that follow an overflowing pair. A forced carry output that reached only the sum XOR, and not the propagate AND, would give wrong upper sum bits. Backpressure is applied with a stall pattern, so a sweeper that advanced or changed fields while stalled would skip or garble records. A stray start and a changed fault code are injected mid-sweep, so a design that restarted or re-sampled the code would break the ascending order or tag records with the wrong code.

// File: rtl/fsa_pkg.sv
// Shared constants and types for the fault sweep adder.
// Assumes the fault code layout of two control bits per forcible net.
package fsa_pkg;

    // Number of forcible nets in the adder and width of the fault code.
    localparam int NUM_SITES = 7;
    localparam int CODE_W    = 2 * NUM_SITES;

    // Net index inside the fault code (bits [2k+1:2k]).
    localparam int SITE_X1       = 0;
    localparam int SITE_X2       = 1;
    localparam int SITE_XOR1     = 2;
    localparam int SITE_AND_GEN  = 3;
    localparam int SITE_AND_PROP = 4;
    localparam int SITE_OR_D     = 5;
    localparam int SITE_CARRY_Q  = 6;

    // Sweep controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EMIT  = 2'd2,
        ST_DONE  = 2'd3
    } sweep_state_e;

endpackage

// File: rtl/fsa_stuck_net.sv
// One forcible net: passes its input or holds a constant.
// ctl[1] enables forcing and ctl[0] is the forced value.
module fsa_stuck_net (
    input  logic       net_in,
    input  logic [1:0] ctl,
    output logic       net_out
);

    // Select the live value or the stuck constant.
    assign net_out = ctl[1] ? ctl[0] : net_in;

endmodule

// File: rtl/fsa_serial_adder.sv
// Bit-serial full adder with one carry register and seven forcible nets.
// Sum bits are shifted into sum_word from the top, so after WORD_W
// advances the first bit sits at bit 0. clr zeroes the carry and has
// priority over adv. Assumes the controller gives exactly WORD_W advances
// per word.
module fsa_serial_adder
    import fsa_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic              x1,
    input  logic              x2,
    input  logic [CODE_W-1:0] fault_code,
    output logic [WORD_W-1:0] sum_word
);

    logic x1_f, x2_f;
    logic xor1_raw, xor1_f;
    logic gen_raw, gen_f;
    logic prop_raw, prop_f;
    logic d_raw, d_f;
    logic carry_q, carry_f;
    logic sum_bit;

    // Forcible operand inputs.
    fsa_stuck_net u_x1 (.net_in(x1), .ctl(fault_code[2*SITE_X1 +: 2]), .net_out(x1_f));
    fsa_stuck_net u_x2 (.net_in(x2), .ctl(fault_code[2*SITE_X2 +: 2]), .net_out(x2_f));

    // First XOR: half-sum of the operand bits.
    assign xor1_raw = x1_f ^ x2_f;
    fsa_stuck_net u_xor1 (.net_in(xor1_raw), .ctl(fault_code[2*SITE_XOR1 +: 2]), .net_out(xor1_f));

    // Generate AND.
    assign gen_raw = x1_f & x2_f;
    fsa_stuck_net u_gen (.net_in(gen_raw), .ctl(fault_code[2*SITE_AND_GEN +: 2]), .net_out(gen_f));

    // Carry register output as seen by the rest of the logic.
    fsa_stuck_net u_cq (.net_in(carry_q), .ctl(fault_code[2*SITE_CARRY_Q +: 2]), .net_out(carry_f));

    // Propagate AND.
    assign prop_raw = xor1_f & carry_f;
    fsa_stuck_net u_prop (.net_in(prop_raw), .ctl(fault_code[2*SITE_AND_PROP +: 2]), .net_out(prop_f));

    // OR gate that feeds the carry register.
    assign d_raw = gen_f | prop_f;
    fsa_stuck_net u_d (.net_in(d_raw), .ctl(fault_code[2*SITE_OR_D +: 2]), .net_out(d_f));

    // Second XOR: the sum bit of this clock.
    assign sum_bit = xor1_f ^ carry_f;

    // Carry register: cleared per word, loaded on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (clr) begin
            carry_q <= 1'b0;
        end else if (adv) begin
            carry_q <= d_f;
        end
    end

    // Sum collector: shift each new bit in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_word <= '0;
        end else if (adv) begin
            sum_word <= {sum_bit, sum_word[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/fsa_sweep_ctrl.sv
// Sweep sequencer: samples the fault code on start, walks all operand
// pairs in ascending order, gives WORD_W shift cycles per pair and then
// holds the record until it is accepted. Start is ignored outside idle/done.
// Assumes WORD_W >= 2.
module fsa_sweep_ctrl
    import fsa_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CODE_W-1:0]   fault_cfg,
    input  logic                rec_ready,
    output logic                clr,
    output logic                adv,
    output logic [$clog2(WORD_W)-1:0] bit_idx,
    output logic [2*WORD_W-1:0] pair,
    output logic [CODE_W-1:0]   code_q,
    output logic                rec_valid,
    output logic                done
);

    localparam int BIT_W  = $clog2(WORD_W);
    localparam int PAIR_W = 2 * WORD_W;

    sweep_state_e state;
    logic         launch;
    logic         accept;
    logic         last_bit;
    logic         last_pair;

    // Decode the events that move the sequence on.
    always_comb begin
        launch    = ((state == ST_IDLE) || (state == ST_DONE)) && start;
        accept    = (state == ST_EMIT) && rec_ready;
        last_bit  = (bit_idx == BIT_W'(WORD_W - 1));
        last_pair = &pair;
        clr       = launch || (accept && !last_pair);
        adv       = (state == ST_SHIFT);
        rec_valid = (state == ST_EMIT);
        done      = (state == ST_DONE);
    end

    // State, bit counter, pair counter and sampled fault code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            pair    <= '0;
            code_q  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state   <= ST_SHIFT;
                        bit_idx <= '0;
                        pair    <= '0;
                        code_q  <= fault_cfg;
                    end
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        state   <= ST_EMIT;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + BIT_W'(1);
                    end
                end
                ST_EMIT: begin
                    if (rec_ready) begin
                        if (last_pair) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_SHIFT;
                            pair  <= pair + PAIR_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fault_sweep_adder.sv
// Top level: a faulted serial adder and a fault-free copy share one
// sweep controller. Each record presents the operand pair, the faulted
// sum, the sampled fault code and a mismatch flag. x1 is the high word
// of the operand pair and x2 the low word.
module fault_sweep_adder
    import fsa_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CODE_W-1:0]   fault_cfg,
    input  logic                rec_ready,
    output logic                rec_valid,
    output logic [2*WORD_W-1:0] rec_operands,
    output logic [WORD_W-1:0]   rec_sum,
    output logic [CODE_W-1:0]   rec_fault,
    output logic                rec_mismatch,
    output logic                done
);

    localparam int BIT_W = $clog2(WORD_W);

    logic                clr;
    logic                adv;
    logic [BIT_W-1:0]    bit_idx;
    logic [2*WORD_W-1:0] pair;
    logic [CODE_W-1:0]   code_q;
    logic [WORD_W-1:0]   x1_word, x2_word;
    logic                x1_bit, x2_bit;
    logic [WORD_W-1:0]   sum_faulty, sum_clean;

    // Sequencer.
    fsa_sweep_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fault_cfg (fault_cfg),
        .rec_ready (rec_ready),
        .clr       (clr),
        .adv       (adv),
        .bit_idx   (bit_idx),
        .pair      (pair),
        .code_q    (code_q),
        .rec_valid (rec_valid),
        .done      (done)
    );

    // Serialise the current pair, low bit first.
    always_comb begin
        x1_word = pair[2*WORD_W-1:WORD_W];
        x2_word = pair[WORD_W-1:0];
        x1_bit  = x1_word[bit_idx];
        x2_bit  = x2_word[bit_idx];
    end

    // Adder under the sampled fault code.
    fsa_serial_adder #(.WORD_W(WORD_W)) u_faulty (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .adv        (adv),
        .x1         (x1_bit),
        .x2         (x2_bit),
        .fault_code (code_q),
        .sum_word   (sum_faulty)
    );

    // Fault-free reference copy.
    fsa_serial_adder #(.WORD_W(WORD_W)) u_clean (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .adv        (adv),
        .x1         (x1_bit),
        .x2         (x2_bit),
        .fault_code ({CODE_W{1'b0}}),
        .sum_word   (sum_clean)
    );

    // Record fields.
    always_comb begin
        rec_operands = pair;
        rec_sum      = sum_faulty;
        rec_fault    = code_q;
        rec_mismatch = (sum_faulty != sum_clean);
    end

endmodule

// File: rtl/fsa_sweep_checker.sv
// Protocol and ordering properties of the record stream, bound to the top.
module fsa_sweep_checker
    import fsa_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rec_valid,
    input logic                rec_ready,
    input logic [2*WORD_W-1:0] rec_operands,
    input logic [WORD_W-1:0]   rec_sum,
    input logic [CODE_W-1:0]   rec_fault,
    input logic                rec_mismatch,
    input logic                done
);

    localparam int PAIR_W = 2 * WORD_W;

    logic              seen;
    logic [PAIR_W-1:0] last_ops;
    logic [CODE_W-1:0] last_fault;

    // Remember the last accepted record of the current sweep.
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            seen       <= 1'b0;
            last_ops   <= '0;
            last_fault <= '0;
        end else if (rec_valid && rec_ready) begin
            seen       <= 1'b1;
            last_ops   <= rec_operands;
            last_fault <= rec_fault;
        end
    end

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!rec_valid && !done));

    p_hold_when_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_operands) && $stable(rec_sum)
                                       && $stable(rec_fault) && $stable(rec_mismatch)));

    p_first_pair_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rec_valid) && !seen) |-> (rec_operands == '0));

    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rec_valid) && seen) |-> (rec_operands == last_ops + PAIR_W'(1)));

    p_code_constant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && seen) |-> (rec_fault == last_fault));

    p_clean_no_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (rec_fault == '0)) |-> !rec_mismatch);

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rec_valid && rec_ready && (&rec_operands)));

    p_done_excludes_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rec_valid);

    p_gap_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready && !(&rec_operands)) |=> !rec_valid);

endmodule

bind fault_sweep_adder fsa_sweep_checker #(.WORD_W(WORD_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_operands (rec_operands),
    .rec_sum      (rec_sum),
    .rec_fault    (rec_fault),
    .rec_mismatch (rec_mismatch),
    .done         (done)
);

// File: tb/fault_sweep_adder_tb.sv
`timescale 1ns/1ps
module fault_sweep_adder_tb;

    localparam int W  = 4;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [CW-1:0] fault_cfg;
    logic          rec_ready;
    logic          rec_valid;
    logic [2*W-1:0] rec_operands;
    logic [W-1:0]  rec_sum;
    logic [CW-1:0] rec_fault;
    logic          rec_mismatch;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fault_sweep_adder #(.WORD_W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fault_cfg    (fault_cfg),
        .rec_ready    (rec_ready),
        .rec_valid    (rec_valid),
        .rec_operands (rec_operands),
        .rec_sum      (rec_sum),
        .rec_fault    (rec_fault),
        .rec_mismatch (rec_mismatch),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic frc(input logic v, input logic [1:0] c);
        return c[1] ? c[0] : v;
    endfunction

    // Behavioural model of the faulted adder for one operand pair.
    function automatic logic [W-1:0] model_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic [CW-1:0] code);
        logic c = 1'b0;
        logic [W-1:0] s = '0;
        for (int i = 0; i < W; i++) begin
            logic p1, p2, hx, g, cq, h, d;
            p1 = frc(a[i], code[1:0]);
            p2 = frc(b[i], code[3:2]);
            hx = frc(p1 ^ p2, code[5:4]);
            g  = frc(p1 & p2, code[7:6]);
            cq = frc(c, code[13:12]);
            h  = frc(hx & cq, code[9:8]);
            d  = frc(g | h, code[11:10]);
            s[i] = hx ^ cq;
            c = d;
        end
        return s;
    endfunction

    function automatic logic [CW-1:0] site(input int k, input bit v);
        logic [CW-1:0] r = '0;
        r[2*k+1] = 1'b1;
        r[2*k]   = v;
        return r;
    endfunction

    function automatic int active_sites(input logic [CW-1:0] code);
        int n = 0;
        for (int k = 0; k < CW/2; k++) if (code[2*k+1]) n++;
        return n;
    endfunction

    // mode 0: ready high; mode 1: stall pattern; mode 2: start poke and code change mid-sweep
    task automatic run_sweep(input logic [CW-1:0] code, input int mode);
        int cyc = 0;
        int pair = 0;
        int spin = 0;
        bit holding = 0;
        logic [2*W-1:0] h_ops;
        logic [W-1:0]   h_sum;
        logic [CW-1:0]  h_fault;
        logic           h_mis;
        bit prev_ovf = 0;
        string tag;
        @(negedge clk);
        fault_cfg = code;
        start     = 1'b1;
        rec_ready = (mode != 1);
        while (pair < 256 && spin < 4000) begin
            @(negedge clk);
            cyc++;
            spin++;
            start = 1'b0;
            if (pair == 0 && cyc == 1)
                check(done == 1'b0, "R9", "done cleared by start", done, 0);
            if (mode == 2 && pair == 100 && cyc == 2) begin
                start     = 1'b1;  // R12: ignored while busy
                fault_cfg = ~code; // R10: ignored while busy
            end
            if (holding) begin
                check(rec_valid && rec_operands == h_ops && rec_sum == h_sum &&
                      rec_fault == h_fault && rec_mismatch == h_mis,
                      "R7", "record held while stalled", rec_operands, h_ops);
                holding = 0;
            end
            if (rec_valid) begin
                logic [W-1:0] a, b, es, ec;
                rec_ready = (mode == 1) ? (cyc % 3 == 0) : 1'b1;
                if (mode != 1)
                    check(cyc == 5, "R6", "cycles to record", cyc, 5);
                if (rec_ready) begin
                    a  = W'(pair >> W);
                    b  = W'(pair);
                    es = model_sum(a, b, code);
                    ec = model_sum(a, b, '0);
                    if (code == '0 || active_sites(code) == 0) tag = prev_ovf ? "R2" : "R1";
                    else if (active_sites(code) == 1)          tag = "R3";
                    else                                       tag = "R4";
                    check(rec_operands == 8'(pair), (mode == 2) ? "R12" : "R5",
                          "operand order", rec_operands, pair);
                    check(rec_sum == es, tag, "sum", rec_sum, es);
                    check(rec_fault == code, "R10", "fault code", rec_fault, code);
                    check(rec_mismatch == (es != ec), "R8", "mismatch",
                          rec_mismatch, (es != ec));
                    prev_ovf = (int'(a) + int'(b)) > 15;
                    pair++;
                    cyc  = 0;
                    spin = 0;
                end else begin
                    holding = 1;
                    h_ops   = rec_operands;
                    h_sum   = rec_sum;
                    h_fault = rec_fault;
                    h_mis   = rec_mismatch;
                end
            end
        end
        check(spin < 4000, "R5", "sweep stalled", spin, 0);
        rec_ready = 1'b1;
        @(negedge clk);
        check(done == 1'b1 && rec_valid == 1'b0, "R9", "done after last record",
              {done, rec_valid}, 2);
        repeat (3) @(negedge clk);
        check(done == 1'b1 && rec_valid == 1'b0, "R9", "done held", {done, rec_valid}, 2);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        fault_cfg = '0;
        rec_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(rec_valid == 1'b0 && done == 1'b0, "R11", "outputs in reset",
              {rec_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rec_valid == 1'b0 && done == 1'b0, "R11", "outputs after reset",
              {rec_valid, done}, 0);

        run_sweep('0, 0);
        for (int k = 0; k < CW/2; k++) begin
            run_sweep(site(k, 1'b0), 0);
            run_sweep(site(k, 1'b1), 0);
        end
        run_sweep(14'b00_00_00_00_00_00_01, 0);            // R3: 01 means no fault
        run_sweep(site(0, 1'b0) | site(1, 1'b1), 0);        // R4
        run_sweep(site(2, 1'b1) | site(6, 1'b0), 0);        // R4
        run_sweep(site(3, 1'b1) | site(5, 1'b0), 0);        // R4
        run_sweep(site(4, 1'b1) | site(0, 1'b1), 0);        // R4
        run_sweep(site(6, 1'b1), 1);                        // R7 backpressure
        run_sweep(site(5, 1'b1) | site(2, 1'b0), 2);        // R10, R12

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule